// File: doc/BRIEF.md
# Delayed Read Transaction Tracker

This block sits behind the target side of a bus bridge and manages a single delayed read. A read that cannot be answered at once is told to retry. Its address, command and byte enables are captured, passed across the bridge, and the returning word is parked as a completion. When the initiator comes back with the identical read, the parked word is returned and the slot becomes free again. The block works on a simple request/response handshake rather than on raw bus pins.

A configuration bit enables or disables target operation. Turning the target off throws away a request that is still in flight. A parked completion is kept through the disable and is still delivered after re-enable. A parked completion is discarded if nobody asks for it within 2^TMO_W clock cycles, and this timer keeps running while the target is disabled. If a far-side answer arrives for a request that was already thrown away, it is swallowed. No new request is sent across until that stale answer has come back.

Top module: `drt_tracker`

## Requirements
- R1: After reset the block holds nothing: `fwdValid`, `rspRetry`, `rspHit`, `dropTimeout` and `dropDisable` are all 0.
- R2: An enabled read while the slot is empty is answered with `rspRetry`=1 in the following cycle. From then on `fwdValid`=1 carries its address, command and byte enables, and stays asserted until `fwdReady` is seen.
- R3: Once a completion is parked, an enabled read with equal address, command and byte enables gets `rspHit`=1 and `rspData` equal to the parked word in the following cycle. The slot is then free, so the same read repeated afterwards gets retry and is forwarded anew.
- R4: While the slot is busy, a read that differs in any of address, command or byte enables gets retry and does not replace the held request. A matching read that arrives before the completion also gets retry.
- R5: While `targetEn`=0, reads get neither retry nor hit in the following cycle.
- R6: Clearing `targetEn` while a request is held but not completed frees the slot and gives a one-cycle `dropDisable` pulse. If the far side had already accepted it, the next completion is dropped, and no new request is forwarded until that completion arrives.
- R7: Clearing `targetEn` while a completion is parked raises no pulse and keeps the completion. It is delivered by a matching read after re-enable.
- R8: A parked completion that is not claimed is discarded in the 2^TMO_W-th cycle after it was loaded, with a one-cycle `dropTimeout` pulse. This happens whether or not the target is enabled meanwhile, and a later read then gets retry.
- R9: A matching read presented in the last cycle before the discard is served with `rspHit`, and no `dropTimeout` pulse follows.
- R10: A completion arriving in the same cycle in which `targetEn` is low is not stored. `dropDisable` pulses, and a later read is forwarded at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| targetEn | input | 1 | Target enable configuration bit |
| reqValid | input | 1 | A read is presented this cycle |
| reqAddr | input | ADDR_W | Read address |
| reqCmd | input | CMD_W | Read command code |
| reqBe | input | BE_W | Read byte enables |
| rspRetry | output | 1 | Read presented last cycle is told to retry |
| rspHit | output | 1 | Read presented last cycle is served with data |
| rspData | output | DATA_W | Parked word when `rspHit` is 1, else 0 |
| fwdValid | output | 1 | Held request offered to the far side |
| fwdReady | input | 1 | Far side accepts the offered request |
| fwdAddr | output | ADDR_W | Held address |
| fwdCmd | output | CMD_W | Held command |
| fwdBe | output | BE_W | Held byte enables |
| cplValid | input | 1 | Far side returns a completion word |
| cplData | input | DATA_W | Completion word |
| dropTimeout | output | 1 | One-cycle pulse: parked completion aged out |
| dropDisable | output | 1 | One-cycle pulse: held request discarded by disable |

## Verification
Two pairs of events can land on the same clock edge. A repeat read can arrive in the very cycle the discard timer expires, and a far-side completion can arrive in the cycle the enable bit falls. The bench parks a completion, idles for exactly 2^16−1 cycles and then presents the matching read. It expects a hit with the parked word and no timeout pulse afterwards. In a separate run it raises the completion and lowers the enable together, and expects a disable pulse and a fresh forward on the next read, which proves that nothing was stored.

// File: rtl/drt_pkg.sv
package drt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_HELD
  } drt_state_e;

  typedef struct packed {
    logic latchReq;
    logic loadCpl;
    logic runCnt;
  } drt_strobe_t;

endpackage

// File: rtl/drt_datapath.sv
module drt_datapath #(
  parameter int ADDR_W = 16,
  parameter int CMD_W  = 4,
  parameter int BE_W   = 4,
  parameter int DATA_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  drt_pkg::drt_strobe_t strobe,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic [CMD_W-1:0]    inCmd,
  input  logic [BE_W-1:0]     inBe,
  input  logic [DATA_W-1:0]   cplData,
  output logic [ADDR_W-1:0]   heldAddr,
  output logic [CMD_W-1:0]    heldCmd,
  output logic [BE_W-1:0]     heldBe,
  output logic [DATA_W-1:0]   heldData,
  output logic                reqMatch,
  output logic                cntAtMax
);

  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] ageCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldCmd  <= '0;
      heldBe   <= '0;
    end else if (strobe.latchReq) begin
      heldAddr <= inAddr;
      heldCmd  <= inCmd;
      heldBe   <= inBe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldData <= '0;
      ageCnt   <= '0;
    end else if (strobe.loadCpl) begin
      heldData <= cplData;
      ageCnt   <= '0;
    end else if (strobe.runCnt) begin
      ageCnt   <= ageCnt + 1'b1;
    end
  end

  assign reqMatch = (inAddr == heldAddr) && (inCmd == heldCmd) && (inBe == heldBe);
  assign cntAtMax = (ageCnt == CNT_MAX);

endmodule

// File: rtl/drt_ctrl.sv
module drt_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 targetEn,
  input  logic                 reqValid,
  input  logic                 reqMatch,
  input  logic                 cntAtMax,
  input  logic                 fwdReady,
  input  logic                 cplValid,
  output drt_pkg::drt_strobe_t strobe,
  output logic                 fwdValid,
  output logic                 rspRetry,
  output logic                 rspHit,
  output logic                 dropTimeout,
  output logic                 dropDisable
);
  import drt_pkg::*;

  drt_state_e state, stateNxt;
  logic orphan, orphanNxt;
  logic retryNxt, hitNxt, toNxt, disNxt;
  logic claim, fwdFire;

  assign claim    = targetEn && reqValid;
  assign fwdValid = (state == ST_REQ) && !orphan;
  assign fwdFire  = fwdValid && fwdReady;

  always_comb begin
    stateNxt  = state;
    orphanNxt = orphan;
    retryNxt  = 1'b0;
    hitNxt    = 1'b0;
    toNxt     = 1'b0;
    disNxt    = 1'b0;
    strobe    = '0;
    if (orphan && cplValid) orphanNxt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (claim) begin
          strobe.latchReq = 1'b1;
          retryNxt        = 1'b1;
          stateNxt        = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!targetEn) begin
          stateNxt = ST_IDLE;
          disNxt   = 1'b1;
          if (fwdFire) orphanNxt = 1'b1;
        end else begin
          retryNxt = reqValid;
          if (fwdFire) stateNxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!targetEn) begin
          stateNxt = ST_IDLE;
          disNxt   = 1'b1;
          if (!cplValid) orphanNxt = 1'b1;
        end else begin
          retryNxt = reqValid;
          if (cplValid) begin
            strobe.loadCpl = 1'b1;
            stateNxt       = ST_HELD;
          end
        end
      end
      ST_HELD: begin
        if (claim && reqMatch) begin
          hitNxt   = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          retryNxt = claim;
          if (cntAtMax) begin
            toNxt    = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            strobe.runCnt = 1'b1;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      orphan      <= 1'b0;
      rspRetry    <= 1'b0;
      rspHit      <= 1'b0;
      dropTimeout <= 1'b0;
      dropDisable <= 1'b0;
    end else begin
      state       <= stateNxt;
      orphan      <= orphanNxt;
      rspRetry    <= retryNxt;
      rspHit      <= hitNxt;
      dropTimeout <= toNxt;
      dropDisable <= disNxt;
    end
  end

endmodule

// File: rtl/drt_tracker.sv
module drt_tracker #(
  parameter int ADDR_W = 16,
  parameter int CMD_W  = 4,
  parameter int BE_W   = 4,
  parameter int DATA_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              targetEn,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [BE_W-1:0]   reqBe,
  output logic              rspRetry,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              fwdValid,
  input  logic              fwdReady,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [CMD_W-1:0]  fwdCmd,
  output logic [BE_W-1:0]   fwdBe,
  input  logic              cplValid,
  input  logic [DATA_W-1:0] cplData,
  output logic              dropTimeout,
  output logic              dropDisable
);

  drt_pkg::drt_strobe_t strobe;
  logic reqMatch, cntAtMax;
  logic [DATA_W-1:0] heldData;

  drt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .targetEn(targetEn), .reqValid(reqValid),
    .reqMatch(reqMatch), .cntAtMax(cntAtMax), .fwdReady(fwdReady),
    .cplValid(cplValid), .strobe(strobe), .fwdValid(fwdValid),
    .rspRetry(rspRetry), .rspHit(rspHit), .dropTimeout(dropTimeout),
    .dropDisable(dropDisable)
  );

  drt_datapath #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .BE_W(BE_W), .DATA_W(DATA_W), .TMO_W(TMO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(reqAddr), .inCmd(reqCmd),
    .inBe(reqBe), .cplData(cplData), .heldAddr(fwdAddr), .heldCmd(fwdCmd),
    .heldBe(fwdBe), .heldData(heldData), .reqMatch(reqMatch), .cntAtMax(cntAtMax)
  );

  assign rspData = rspHit ? heldData : '0;

endmodule

// File: rtl/drt_checker.sv
module drt_checker (
  input logic clk,
  input logic rstN,
  input logic targetEn,
  input logic reqValid,
  input logic fwdValid,
  input logic fwdReady,
  input logic rspRetry,
  input logic rspHit,
  input logic dropTimeout,
  input logic dropDisable
);

  a_r3_retry_hit_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rspRetry && rspHit));

  a_r3_hit_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> $past(reqValid && targetEn));

  a_r5_disabled_unclaimed: assert property (@(posedge clk) disable iff (!rstN)
    !targetEn |=> (!rspRetry && !rspHit));

  a_r2_fwd_held: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady && targetEn) |=> fwdValid);

  a_r6_disable_cause: assert property (@(posedge clk) disable iff (!rstN)
    dropDisable |-> $past(!targetEn));

  a_r8_drops_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dropTimeout && dropDisable));

  a_r9_hit_beats_timeout: assert property (@(posedge clk) disable iff (!rstN)
    dropTimeout |-> !rspHit);

endmodule

bind drt_tracker drt_checker u_chk (.*);

// File: tb/drt_tracker_bench.sv
`timescale 1ns/1ps
module drt_tracker_bench;

  localparam int TMO_CYC = 65536;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic targetEn = 1'b1;
  logic reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [3:0]  reqCmd = '0;
  logic [3:0]  reqBe = '0;
  logic fwdReady = 1'b0;
  logic cplValid = 1'b0;
  logic [15:0] cplData = '0;
  logic rspRetry, rspHit, fwdValid, dropTimeout, dropDisable;
  logic [15:0] rspData, fwdAddr;
  logic [3:0]  fwdCmd, fwdBe;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  drt_tracker u_drt_tracker (
    .clk(clk), .rstN(rstN), .targetEn(targetEn), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqCmd(reqCmd), .reqBe(reqBe), .rspRetry(rspRetry),
    .rspHit(rspHit), .rspData(rspData), .fwdValid(fwdValid), .fwdReady(fwdReady),
    .fwdAddr(fwdAddr), .fwdCmd(fwdCmd), .fwdBe(fwdBe), .cplValid(cplValid),
    .cplData(cplData), .dropTimeout(dropTimeout), .dropDisable(dropDisable)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(logic [15:0] a, logic [3:0] c, logic [3:0] b);
    reqAddr = a; reqCmd = c; reqBe = b; reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
  endtask

  task automatic handshake();
    fwdReady = 1'b1; tick(); fwdReady = 1'b0;
  endtask

  task automatic complete(logic [15:0] d);
    cplData = d; cplValid = 1'b1; tick(); cplValid = 1'b0;
  endtask

  task automatic dropReq(string tag);
    targetEn = 1'b0; tick(); targetEn = 1'b1;
    chk(tag, dropDisable, 1);
    tick();
    chk(tag, dropDisable, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finishRun();
    end
  end

  initial begin
    logic [15:0] a, d;
    logic [3:0] c, b;
    bit early;
    tick(); tick(); tick();
    // R1 reset state
    chk("R1 fwdValid", fwdValid, 0);
    chk("R1 rspRetry", rspRetry, 0);
    chk("R1 rspHit", rspHit, 0);
    chk("R1 drops", {dropTimeout, dropDisable}, 0);
    rstN = 1'b1;
    tick();
    chk("R1 idle after release", {fwdValid, rspRetry, rspHit}, 0);

    for (int i = 0; i < 8; i++) begin
      a = 16'(i * 16'h1357 + 16'h0040);
      c = 4'(i + 2);
      b = 4'(~i);
      d = 16'(i * 16'h0F1D + 16'h00A5);
      rd(a, c, b);
      chk("R2 retry on new read", rspRetry, 1);
      chk("R2 no hit on new read", rspHit, 0);
      chk("R2 fwdValid", fwdValid, 1);
      chk("R2 fwd fields", {fwdAddr, fwdCmd, fwdBe}, {a, c, b});
      rd(a ^ 16'h0001, c, b);
      chk("R4 mismatch retried", rspRetry, 1);
      chk("R4 held unchanged", {fwdAddr, fwdCmd, fwdBe}, {a, c, b});
      tick();
      chk("R2 fwdValid held", fwdValid, 1);
      handshake();
      chk("R2 fwdValid after accept", fwdValid, 0);
      rd(a, c, b);
      chk("R4 early match retried", {rspRetry, rspHit}, 2'b10);
      complete(d);
      rd(a, c ^ 4'h1, b);
      chk("R4 cmd mismatch retried", {rspRetry, rspHit}, 2'b10);
      rd(a, c, b ^ 4'h8);
      chk("R4 be mismatch retried", {rspRetry, rspHit}, 2'b10);
      if (i % 2 == 1) begin
        targetEn = 1'b0;
        rd(a, c, b);
        chk("R5 disabled unclaimed", {rspRetry, rspHit}, 0);
        for (int k = 0; k < i; k++) tick();
        chk("R7 no drop on disable", {dropDisable, dropTimeout}, 0);
        targetEn = 1'b1;
      end
      rd(a, c, b);
      chk("R3 hit", rspHit, 1);
      chk("R3 data", rspData, d);
      chk("R3 no retry on hit", rspRetry, 0);
      rd(a, c, b);
      chk("R3 freed then retried", {rspRetry, rspHit}, 2'b10);
      chk("R3 forwarded anew", fwdValid, 1);
      dropReq("R6 drop held request");
    end

    // R6 disable after far side accepted; stale completion dropped
    rd(16'hA000, 4'h6, 4'hF);
    handshake();
    dropReq("R6 drop issued request");
    rd(16'hB000, 4'h6, 4'h3);
    chk("R6 retry while stale", rspRetry, 1);
    chk("R6 forward blocked", fwdValid, 0);
    complete(16'hDEAD);
    chk("R6 forward after stale", fwdValid, 1);
    chk("R6 fields", {fwdAddr, fwdCmd, fwdBe}, {16'hB000, 4'h6, 4'h3});
    rd(16'hB000, 4'h6, 4'h3);
    chk("R6 stale not stored", {rspRetry, rspHit}, 2'b10);
    handshake();
    complete(16'h1234);
    rd(16'hB000, 4'h6, 4'h3);
    chk("R6 fresh data", {rspHit, rspData}, {1'b1, 16'h1234});

    // R10 completion in disable cycle
    rd(16'hC000, 4'h6, 4'h1);
    handshake();
    cplData = 16'hBEEF; cplValid = 1'b1; targetEn = 1'b0;
    tick();
    cplValid = 1'b0; targetEn = 1'b1;
    chk("R10 disable pulse", dropDisable, 1);
    rd(16'hC000, 4'h6, 4'h1);
    chk("R10 not stored", {rspRetry, rspHit}, 2'b10);
    chk("R10 forwarded at once", fwdValid, 1);
    dropReq("R10 cleanup");

    // R8 timeout, with a disabled stretch
    rd(16'hE000, 4'h6, 4'h5);
    handshake();
    complete(16'h5555);
    early = 1'b0;
    for (int k = 1; k < TMO_CYC; k++) begin
      targetEn = !(k >= 100 && k <= 30000);
      tick();
      if (dropTimeout || dropDisable) early = 1'b1;
    end
    targetEn = 1'b1;
    chk("R8 no early discard", early, 0);
    tick();
    chk("R8 timeout pulse", dropTimeout, 1);
    rd(16'hE000, 4'h6, 4'h5);
    chk("R8 discarded", {rspRetry, rspHit, dropTimeout}, 3'b100);
    dropReq("R8 cleanup");

    // R9 hit in final cycle beats timeout
    rd(16'hF000, 4'h6, 4'h9);
    handshake();
    complete(16'h9999);
    for (int k = 1; k < TMO_CYC; k++) tick();
    rd(16'hF000, 4'h6, 4'h9);
    chk("R9 last-cycle hit", {rspHit, rspData}, {1'b1, 16'h9999});
    chk("R9 no timeout", dropTimeout, 0);
    tick();
    chk("R9 no later timeout", dropTimeout, 0);

    finishRun();
  end

endmodule